// File: doc/BRIEF.md
# Periodic Delay Trigger Scheduler

This block paces the conversions of a multi-channel ADC controller. It contains four delay channels. Each one counts down a programmed number of time-base ticks and then fires. When it fires it pulses a chosen set of converter-slot trigger lines and a chosen set of delay channels. It then reloads and repeats for as many loops as it was given. A channel that receives a pulse from another channel starts as though software had kicked it. Delay channels can therefore be chained into a periodic acquisition schedule that runs without software.

Software programs the bank through a small write/read register port. Each channel has a single 32-bit register that can be reached at three write addresses. One address writes the register outright, one ORs bits in, and one clears bits. A prescaler divides the system clock into the slow time-base tick. At 125 MHz with the default divider the tick runs at 2 kHz, so a delay of 200 fires every 100 ms.

Top module: `dts_sched_top`

## Requirements
- R1: After a synchronous active-low reset, every channel register reads 0, no slot trigger is asserted and the tick output is low.
- R2: The channel register layout is delay in bits [10:0], loop count in [15:11], delay-channel trigger mask in [19:16], run (kick) bit in 20 and converter-slot mask in [31:24]. Bits 21 to 23 are not stored and read as 0.
- R3: The set alias ORs the written bits into the register. The clear alias removes the written bits from it. The plain alias replaces the register.
- R4: Channel n is placed at BASE_ADDR + 0x10*n. Offset +0x0 is the plain alias, +0x4 the set alias and +0x8 the clear alias. Reads return the register at the +0x0 address and 0 everywhere else.
- R5: tick_o is a one-clock pulse every TICK_DIV system clocks.
- R6: A channel that is started fires after max(delay,1) ticks. Firing raises slot_trig_o for exactly one clock, carrying that channel's slot mask, in the clock after the expiring tick.
- R7: A channel with loop count L fires L+1 times, max(delay,1) ticks apart. Each firing with a nonzero loop count decrements the field. The final firing leaves the loop field at 0 and clears the run bit, which reads 1 only while the channel runs.
- R8: Clearing the run bit stops the channel. No further firings occur and the loop field keeps its value.
- R9: A firing pulses every delay channel set in the firing channel's delay mask. A stopped channel that receives such a pulse sets its run bit and starts counting as if kicked.
- R10: A channel with an empty slot mask fires without asserting any slot line. Slot lines from several channels are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (channel page and alias offset) |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| tick_o | output | 1 | Time-base tick pulse |
| slot_trig_o | output | NUM_SLOT | Converter-slot trigger pulses |

## Verification
The hardest situation to reach from the ports is a chained start. In that case one channel is started by another channel's firing rather than by a register write, and the second channel's timing must be counted from a pulse that is never visible at the ports. The bench programs a silent target channel with its own loop count and then kicks a source channel whose delay mask points at it. It predicts the tick count of every slot pulse from both delays and both loop counts, and checks the order and spacing of the two slot patterns. The loop-count sweep observes the decrementing loop field and the run bit in the clock of each firing, so that each firing is tied to its register effect.

// File: rtl/dts_pkg.sv
// Shared field positions, write-alias opcodes and the writable-bit mask
// for the delay trigger scheduler. Assumes 32-bit channel registers.
package dts_pkg;

    localparam int DLY_LSB  = 0;
    localparam int DLY_W    = 11;
    localparam int LOOP_LSB = 11;
    localparam int LOOP_W   = 5;
    localparam int DMSK_LSB = 16;
    localparam int DMSK_MAX = 4;
    localparam int KICK_BIT = 20;
    localparam int SMSK_LSB = 24;
    localparam int SMSK_MAX = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PLAIN = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } op_e;

    // Bits of a channel register that hold state for a given bank size.
    function automatic logic [31:0] wr_mask(int nch, int nslot);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < DLY_W; i++)  m[DLY_LSB + i]  = 1'b1;
        for (int i = 0; i < LOOP_W; i++) m[LOOP_LSB + i] = 1'b1;
        for (int i = 0; i < nch; i++)    m[DMSK_LSB + i] = 1'b1;
        m[KICK_BIT] = 1'b1;
        for (int i = 0; i < nslot; i++)  m[SMSK_LSB + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dts_prescaler.sv
// Time-base prescaler: divides the system clock by DIV and produces a
// registered one-clock tick. Assumes DIV >= 1; free-running from reset.
module dts_prescaler #(
    parameter int DIV = 62500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count system clocks and emit a tick when the period wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    if (DIV > 1) begin : g_chk
        a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
    end

endmodule

// File: rtl/dts_regif.sv
// Register address decoder: maps each channel page to a plain, set or clear
// write opcode and muxes the plain-address read. Assumes BASE_ADDR is
// 16-byte aligned and all channel pages fit inside ADDR_W bits.
module dts_regif #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h0D0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_CH-1:0][31:0]  regs_i,
    output dts_pkg::op_e             op_o [NUM_CH],
    output logic [31:0]              rd_data_o
);
    import dts_pkg::*;

    localparam int PW        = ADDR_W - 4;
    localparam int BASE_PAGE = BASE_ADDR / 16;

    logic [NUM_CH-1:0] wr_page_hit;
    logic [NUM_CH-1:0] rd_page_hit;
    op_e               nib_op;

    // Decode the alias offset inside a channel page.
    always_comb begin
        case (wr_addr[3:0])
            4'h0:    nib_op = OP_PLAIN;
            4'h4:    nib_op = OP_SET;
            4'h8:    nib_op = OP_CLR;
            default: nib_op = OP_NONE;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_page
        localparam logic [PW-1:0] PAGE = PW'(BASE_PAGE + g);
        // Match the write and read addresses against this channel's page.
        always_comb begin
            wr_page_hit[g] = wr_en && (wr_addr[ADDR_W-1:4] == PAGE) && (nib_op != OP_NONE);
            rd_page_hit[g] = (rd_addr[ADDR_W-1:4] == PAGE) && (rd_addr[3:0] == 4'h0);
            op_o[g]        = wr_page_hit[g] ? nib_op : OP_NONE;
        end
    end

    // Return the addressed register or zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_page_hit[i]) rd_data_o = regs_i[i];
    end

    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_page_hit));

endmodule

// File: rtl/dts_chan.sv
// One delay channel: holds its register, counts ticks while running, fires
// registered slot and delay-channel pulses on expiry, then reloads or stops.
// Assumes a register write wins over any same-clock tick or incoming
// trigger, and that a trigger reaching a running channel is ignored.
module dts_chan #(
    parameter int NUM_CH   = 4,
    parameter int NUM_SLOT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  dts_pkg::op_e        op_i,
    input  logic [31:0]         wdata_i,
    input  logic                trig_i,
    output logic [31:0]         reg_o,
    output logic [NUM_SLOT-1:0] slot_pulse_o,
    output logic [NUM_CH-1:0]   dly_pulse_o
);
    import dts_pkg::*;

    localparam logic [31:0] WMASK = wr_mask(NUM_CH, NUM_SLOT);

    logic [31:0]       reg_q;
    logic [31:0]       wr_val;
    logic [DLY_W-1:0]  cnt_q;
    logic              fire_q;
    logic              wr_hit;
    logic              expire;

    logic [DLY_W-1:0]  dly;
    logic [LOOP_W-1:0] loops;
    logic              kick;

    assign dly   = reg_q[DLY_LSB +: DLY_W];
    assign loops = reg_q[LOOP_LSB +: LOOP_W];
    assign kick  = reg_q[KICK_BIT];
    assign reg_o = reg_q;

    // Form the register value a write through each alias would leave.
    always_comb begin
        case (op_i)
            OP_PLAIN: wr_val = wdata_i & WMASK;
            OP_SET:   wr_val = (reg_q | wdata_i) & WMASK;
            OP_CLR:   wr_val = reg_q & ~wdata_i;
            default:  wr_val = reg_q;
        endcase
        wr_hit = (op_i != OP_NONE);
        expire = !wr_hit && kick && tick_i && (cnt_q <= DLY_W'(1));
    end

    // Register the expiry pulses toward the slots and the other channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q       <= 1'b0;
            slot_pulse_o <= '0;
            dly_pulse_o  <= '0;
        end else begin
            fire_q       <= expire;
            slot_pulse_o <= expire ? reg_q[SMSK_LSB +: NUM_SLOT] : '0;
            dly_pulse_o  <= expire ? reg_q[DMSK_LSB +: NUM_CH] : '0;
        end
    end

    // Update the register and the tick counter: write, trigger start, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            cnt_q <= '0;
        end else if (wr_hit) begin
            reg_q <= wr_val;
            if (wr_val[KICK_BIT] && !kick)
                cnt_q <= wr_val[DLY_LSB +: DLY_W];
        end else if (trig_i && !kick) begin
            reg_q[KICK_BIT] <= 1'b1;
            cnt_q           <= dly;
        end else if (kick && tick_i) begin
            if (cnt_q <= DLY_W'(1)) begin
                cnt_q <= dly;
                if (loops != '0)
                    reg_q[LOOP_LSB +: LOOP_W] <= loops - 1'b1;
                else
                    reg_q[KICK_BIT] <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    a_r6_fire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(tick_i));
    a_r8_fire_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(kick));
    a_r7_loop_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_q && ($past(loops) != '0)) |-> (loops == $past(loops) - 1'b1) && kick);
    a_r7_final_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_q && ($past(loops) == '0)) |-> !kick);
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SET) |=> ((reg_q & $past(wdata_i & WMASK)) == $past(wdata_i & WMASK)));
    a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLR) |=> ((reg_q & $past(wdata_i)) == '0));

endmodule

// File: rtl/dts_sched_top.sv
// Delay trigger scheduler top: prescaler, register decoder and a bank of
// delay channels cross-connected by their delay-channel trigger masks.
// Assumes NUM_CH <= 4 and NUM_SLOT <= 8 to fit the register layout.
module dts_sched_top #(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOT  = 8,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h0D0,
    parameter int TICK_DIV  = 62500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [31:0]         rd_data,
    output logic                tick_o,
    output logic [NUM_SLOT-1:0] slot_trig_o
);
    dts_pkg::op_e              ch_op   [NUM_CH];
    logic [NUM_CH-1:0][31:0]   ch_regs;
    logic [NUM_SLOT-1:0]       spulse  [NUM_CH];
    logic [NUM_CH-1:0]         dpulse  [NUM_CH];
    logic [NUM_CH-1:0]         trig_in;

    dts_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_o)
    );

    dts_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .regs_i    (ch_regs),
        .op_o      (ch_op),
        .rd_data_o (rd_data)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dts_chan #(.NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (tick_o),
            .op_i         (ch_op[g]),
            .wdata_i      (wr_data),
            .trig_i       (trig_in[g]),
            .reg_o        (ch_regs[g]),
            .slot_pulse_o (spulse[g]),
            .dly_pulse_o  (dpulse[g])
        );
    end

    // Merge the per-channel pulses into slot lines and channel start inputs.
    always_comb begin
        slot_trig_o = '0;
        trig_in     = '0;
        for (int j = 0; j < NUM_CH; j++) begin
            slot_trig_o = slot_trig_o | spulse[j];
            trig_in     = trig_in | dpulse[j];
        end
    end

endmodule

// File: tb/tb_dts_sched_top.sv
module tb_dts_sched_top;
    localparam int DIV    = 4;
    localparam int ADDR_W = 12;
    localparam int BASE   = 'h0D0;
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              tick_o;
    logic [7:0]        slot_trig_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dts_sched_top #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_o(tick_o), .slot_trig_o(slot_trig_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [ADDR_W-1:0] chaddr(int ch, int off);
        return ADDR_W'(BASE + 16 * ch + off);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // R6/R7: start one channel and follow every firing until it stops.
    task automatic run_case(int ch, int dly, int loops, logic [7:0] smask);
        int eff, k, ticks, limit;
        logic [31:0] cfg;
        eff   = (dly == 0) ? 1 : dly;
        limit = eff * (loops + 2) + 2;
        cfg   = (32'(smask) << 24) | (32'd1 << 20) | (32'(loops) << 11) | 32'(dly);
        rd_addr = chaddr(ch, 0);
        wr(chaddr(ch, 0), cfg);
        k = 0; ticks = 0;
        while (ticks <= limit) begin
            if (tick_o) ticks++;
            if (slot_trig_o != 8'h00) begin
                k++;
                check("R6 slot pattern", 32'(slot_trig_o), 32'(smask));
                check("R6 R7 firing tick", 32'(ticks), 32'(k * eff));
                check("R7 loop field", 32'(rd_data[15:11]), (k <= loops) ? 32'(loops - k) : 32'd0);
                check("R7 run bit", 32'(rd_data[20]), (k <= loops) ? 32'd1 : 32'd0);
            end
            @(negedge clk);
        end
        check("R7 firing count", 32'(k), 32'(loops + 1));
        rd_chk("R7 fields kept", chaddr(ch, 0), (32'(smask) << 24) | 32'(dly));
    endtask

    initial begin
        int t0, t1, k, ticks;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick in reset", 32'(tick_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) rd_chk("R1 reset value", chaddr(c, 0), 32'd0);
        check("R1 no slot trigger", 32'(slot_trig_o), 32'd0);

        // R5: tick spacing
        t0 = -1; t1 = -1; k = 0;
        while (k < 3) begin
            @(negedge clk);
            if (tick_o) begin
                if (t0 >= 0) check("R5 tick period", 32'(cyc - t0), DIV);
                t0 = cyc; k++;
            end
        end

        // R2, R3, R4: layout and aliases on channel 3
        wr(chaddr(3, 0), 32'hFFEF_FFFF);
        rd_chk("R2 writable bits", chaddr(3, 0), 32'hFF0F_FFFF);
        rd_chk("R4 set alias reads zero", chaddr(3, 4), 32'd0);
        rd_chk("R4 neighbour untouched", chaddr(2, 0), 32'd0);
        wr(chaddr(3, 8), 32'hFFEF_FFFF);
        rd_chk("R3 clear alias", chaddr(3, 0), 32'd0);
        wr(chaddr(3, 4), 32'h0000_0803);
        rd_chk("R3 set alias", chaddr(3, 4 - 4), 32'h0000_0803);
        wr(chaddr(3, 4), 32'h0001_0000);
        rd_chk("R3 set alias OR", chaddr(3, 0), 32'h0001_0803);
        wr(chaddr(3, 8), 32'h0000_0003);
        rd_chk("R3 clear alias AND", chaddr(3, 0), 32'h0001_0800);
        wr(chaddr(3, 0), 32'h00E1_2345);
        rd_chk("R3 plain replace", chaddr(3, 0), 32'h0001_2345);
        wr(chaddr(3, 12), 32'hFFFF_FFFF);
        rd_chk("R4 unmapped offset", chaddr(3, 0), 32'h0001_2345);
        wr(chaddr(3, 0), 32'd0);

        // R6, R7: sweep channels, delays and loop counts
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++)
                for (int l = 0; l < 3; l++)
                    run_case(c, (d == 3) ? 5 : d, (l == 2) ? 3 : l,
                             (8'h01 << ((c + d + l) % 8)) | ((c % 2 == 1) ? 8'h10 : 8'h00));

        // R8: stopping a running channel
        rd_addr = chaddr(1, 0);
        wr(chaddr(1, 0), (32'h22 << 24) | (32'd1 << 20) | (32'd20 << 11) | 32'd3);
        while (slot_trig_o == 8'h00) @(negedge clk);
        wr(chaddr(1, 8), 32'd1 << 20);
        k = 0; ticks = 0;
        while (ticks < 20) begin
            if (tick_o) ticks++;
            if (slot_trig_o != 8'h00) k++;
            @(negedge clk);
        end
        check("R8 no firing after stop", 32'(k), 32'd0);
        rd_chk("R8 stopped register", chaddr(1, 0), (32'h22 << 24) | (32'd19 << 11) | 32'd3);

        // R9, R10: channel 0 starts channel 2 through its delay mask
        wr(chaddr(2, 0), (32'h80 << 24) | (32'd1 << 11) | 32'd3);
        wr(chaddr(0, 0), (32'h01 << 24) | (32'd1 << 20) | (32'b0100 << 16) | 32'd2);
        k = 0; ticks = 0;
        while (ticks <= 14) begin
            if (tick_o) ticks++;
            if (slot_trig_o != 8'h00) begin
                k++;
                check("R9 chained slot pattern", 32'(slot_trig_o), (k == 1) ? 32'h01 : 32'h80);
                check("R9 chained firing tick", 32'(ticks), (k == 1) ? 32'd2 : 32'(2 + 3 * (k - 1)));
            end
            @(negedge clk);
        end
        check("R9 chained firing count", 32'(k), 32'd3);
        rd_chk("R9 target stopped", chaddr(2, 0), (32'h80 << 24) | 32'd3);

        // R10: empty slot mask fires silently while another channel drives slots
        wr(chaddr(3, 0), (32'd1 << 20) | 32'd1);
        wr(chaddr(1, 0), (32'h40 << 24) | (32'd1 << 20) | 32'd1);
        k = 0; ticks = 0;
        while (ticks < 4) begin
            if (tick_o) ticks++;
            if (slot_trig_o != 8'h00) begin
                k++;
                check("R10 only non-empty mask", 32'(slot_trig_o), 32'h40);
            end
            @(negedge clk);
        end
        check("R10 firing count", 32'(k), 32'd1);
        rd_chk("R10 silent channel finished", chaddr(3, 0), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule